// File: doc/BRIEF.md
# Decrement Opcode Decoder

This combinational block looks at one instruction's opcode byte, its ModRM byte and a set of prefix flags that an earlier stage has already pulled out. From these it decides whether the instruction is a decrement-by-one. If it is, the block reports how the decrement is to be carried out: the operand width, whether the destination is a register or memory, the destination register number, and whether an 8-bit register name means a legacy high-byte register. It also reports an undefined-opcode fault when a LOCK prefix is placed on a register destination.

The rules depend on the processor mode, which is given as a single 64-bit-mode input. In 64-bit mode the one-byte register forms are taken over as REX prefixes. The REX bits are honoured only in 64-bit mode. Outside 64-bit mode the REX inputs are treated as zero.

The decoder sits in the decode stage beside the other opcode recognisers. It computes no addresses and performs no memory access or execution.

Top module: `dec_op_decoder`

## Requirements
- R1: Opcode FEh with ModRM bits [5:3] equal to 1 sets `decValid` and reports width code 0 (8 bits). Width codes are 0=8, 1=16, 2=32 and 3=64 bits.
- R2: Opcode FFh with ModRM bits [5:3] equal to 1 sets `decValid`. The width code is 3 if REX is present with W set in 64-bit mode. Otherwise it is 1 if the operand-size override is set, and 2 in all remaining cases.
- R3: Outside 64-bit mode, opcodes 48h to 4Fh set `decValid` with a register destination. The register number is the low three opcode bits, and the width code is 1 with the operand-size override and 2 without it.
- R4: In 64-bit mode, opcodes 48h to 4Fh never set `decValid`.
- R5: Any other byte, including FEh or FFh with ModRM bits [5:3] not equal to 1, drives every output to 0, with no fault.
- R6: For the FEh and FFh forms, `memOperand` is 1 exactly when ModRM bits [7:6] are not 11b. In that case `regNum` is 0.
- R7: For a register destination of the FEh or FFh form, `regNum` is ModRM bits [2:0]. REX.B, when REX is present in 64-bit mode, is added as bit 3.
- R8: `highByteReg` is 1 only for the FEh form with a register destination, no REX, and ModRM bits [2:0] in the range 4 to 7.
- R9: `udFault` is 1 exactly when a decrement is recognised, LOCK is set and the destination is a register. LOCK with a memory destination raises no fault.
- R10: Outside 64-bit mode, the REX present, W and B inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| longMode | input | 1 | 1 when the processor is in 64-bit mode |
| rexPresent | input | 1 | A REX prefix was seen |
| rexWide | input | 1 | REX.W bit |
| rexRmExt | input | 1 | REX.B bit, which extends the ModRM r/m register number |
| sizeOverride | input | 1 | Operand-size override prefix was seen |
| lockPrefix | input | 1 | LOCK prefix was seen |
| opcodeByte | input | 8 | Opcode byte |
| modrmByte | input | 8 | ModRM byte that follows the opcode |
| decValid | output | 1 | Instruction is a decrement |
| opWidth | output | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| memOperand | output | 1 | Destination is memory |
| regNum | output | 4 | Destination register number |
| highByteReg | output | 1 | 8-bit register 4 to 7 names a legacy high byte |
| udFault | output | 1 | Undefined-opcode fault |

## Verification
The bench builds the block with its default parameters: an 8-bit opcode and a 4-bit register number. At this size every opcode, and every ModRM byte of the two long forms, can be swept against all 64 combinations of mode and prefix flags. This reaches every mode boundary, including the 48h to 4Fh bytes in both modes and each high-byte register encoding with and without REX. The other opcodes are swept with one register ModRM and one memory ModRM under every flag combination, which confirms that nothing outside the decrement forms leaks through.

// File: rtl/dec_decode_pkg.sv
package dec_decode_pkg;
  localparam int OPC_W = 8;
  localparam logic [OPC_W-1:0] OPC_BYTE_FORM  = 8'hFE;
  localparam logic [OPC_W-1:0] OPC_WIDE_FORM  = 8'hFF;
  localparam logic [4:0]       OPC_SHORT_HIGH = 5'b01001;
  localparam logic [2:0]       DEC_EXT_FIELD  = 3'd1;

  typedef enum logic [1:0] {
    WID8  = 2'd0,
    WID16 = 2'd1,
    WID32 = 2'd2,
    WID64 = 2'd3
  } opWidth_e;

  typedef struct packed {
    logic formByte;
    logic formWide;
    logic formShort;
    logic memDest;
  } formStrobe_t;
endpackage

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import dec_decode_pkg::*;
(
  input  logic             longMode,
  input  logic             lockPrefix,
  input  logic [OPC_W-1:0] opcodeByte,
  input  logic [7:0]       modrmByte,
  output formStrobe_t      strobe,
  output logic             udFault
);
  logic [1:0] modField;
  logic [2:0] extField;
  logic       anyForm;

  assign modField = modrmByte[7:6];
  assign extField = modrmByte[5:3];

  always_comb begin
    strobe           = '0;
    strobe.formByte  = (opcodeByte == OPC_BYTE_FORM) && (extField == DEC_EXT_FIELD);
    strobe.formWide  = (opcodeByte == OPC_WIDE_FORM) && (extField == DEC_EXT_FIELD);
    strobe.formShort = !longMode && (opcodeByte[OPC_W-1:3] == OPC_SHORT_HIGH);
    strobe.memDest   = (strobe.formByte || strobe.formWide) && (modField != 2'b11);
  end

  assign anyForm = strobe.formByte | strobe.formWide | strobe.formShort;
  assign udFault = anyForm && lockPrefix && !strobe.memDest;
endmodule

// File: rtl/dec_dpath.sv
module dec_dpath
  import dec_decode_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  formStrobe_t      strobe,
  input  logic             longMode,
  input  logic             rexPresent,
  input  logic             rexWide,
  input  logic             rexRmExt,
  input  logic             sizeOverride,
  input  logic [OPC_W-1:0] opcodeByte,
  input  logic [7:0]       modrmByte,
  output logic [1:0]       opWidth,
  output logic [REG_W-1:0] regNum,
  output logic             highByteReg
);
  localparam int FIELD_W = 3;
  localparam int PAD_W   = REG_W - FIELD_W;

  logic     rexActive;
  logic     regDest;
  opWidth_e widthSel;

  assign rexActive = longMode && rexPresent;
  assign regDest   = (strobe.formByte || strobe.formWide || strobe.formShort) && !strobe.memDest;

  always_comb begin
    widthSel = WID8;
    if (strobe.formWide && rexActive && rexWide) widthSel = WID64;
    else if (strobe.formWide || strobe.formShort) widthSel = sizeOverride ? WID16 : WID32;
  end
  assign opWidth = widthSel;

  always_comb begin
    regNum = '0;
    if (regDest) begin
      if (strobe.formShort) regNum = {{PAD_W{1'b0}}, opcodeByte[FIELD_W-1:0]};
      else regNum = {{(PAD_W-1){1'b0}}, rexActive && rexRmExt, modrmByte[FIELD_W-1:0]};
    end
  end

  assign highByteReg = strobe.formByte && regDest && !rexActive && modrmByte[2];

  always_comb begin
    a_r5_one_form: assert ($onehot0({strobe.formByte, strobe.formWide, strobe.formShort}));
    a_r6_mem_needs_long: assert (!strobe.memDest || strobe.formByte || strobe.formWide);
  end
endmodule

// File: rtl/dec_op_decoder.sv
module dec_op_decoder
  import dec_decode_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic             longMode,
  input  logic             rexPresent,
  input  logic             rexWide,
  input  logic             rexRmExt,
  input  logic             sizeOverride,
  input  logic             lockPrefix,
  input  logic [7:0]       opcodeByte,
  input  logic [7:0]       modrmByte,
  output logic             decValid,
  output logic [1:0]       opWidth,
  output logic             memOperand,
  output logic [REG_W-1:0] regNum,
  output logic             highByteReg,
  output logic             udFault
);
  formStrobe_t strobe;

  dec_ctrl u_ctrl (
    .longMode   (longMode),
    .lockPrefix (lockPrefix),
    .opcodeByte (opcodeByte),
    .modrmByte  (modrmByte),
    .strobe     (strobe),
    .udFault    (udFault)
  );

  dec_dpath #(.REG_W(REG_W)) u_dpath (
    .strobe       (strobe),
    .longMode     (longMode),
    .rexPresent   (rexPresent),
    .rexWide      (rexWide),
    .rexRmExt     (rexRmExt),
    .sizeOverride (sizeOverride),
    .opcodeByte   (opcodeByte),
    .modrmByte    (modrmByte),
    .opWidth      (opWidth),
    .regNum       (regNum),
    .highByteReg  (highByteReg)
  );

  assign decValid   = strobe.formByte | strobe.formWide | strobe.formShort;
  assign memOperand = strobe.memDest;

  always_comb begin
    a_r4_no_short_in_long: assert (!(decValid && longMode && opcodeByte[7:3] == 5'b01001));
    a_r9_fault_on_reg_only: assert (!udFault || (decValid && !memOperand && lockPrefix));
    a_r2_wide64_needs_rex: assert (opWidth != 2'd3 || (longMode && rexPresent && rexWide));
    a_r8_high_no_rex: assert (!highByteReg || (opWidth == 2'd0 && !(longMode && rexPresent)));
    a_r6_mem_no_reg: assert (!memOperand || regNum == '0);
  end
endmodule

// File: tb/tb_dec_op_decoder.sv
module tb_dec_op_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic       longMode, rexPresent, rexWide, rexRmExt, sizeOverride, lockPrefix;
  logic [7:0] opcodeByte, modrmByte;
  logic       decValid, memOperand, highByteReg, udFault;
  logic [1:0] opWidth;
  logic [3:0] regNum;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dec_op_decoder dut (
    .longMode(longMode), .rexPresent(rexPresent), .rexWide(rexWide),
    .rexRmExt(rexRmExt), .sizeOverride(sizeOverride), .lockPrefix(lockPrefix),
    .opcodeByte(opcodeByte), .modrmByte(modrmByte), .decValid(decValid),
    .opWidth(opWidth), .memOperand(memOperand), .regNum(regNum),
    .highByteReg(highByteReg), .udFault(udFault)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s op=%02h modrm=%02h flags=%b%b%b%b%b%b actual=%0d expected=%0d",
               tag, what, opcodeByte, modrmByte, longMode, rexPresent, rexWide,
               rexRmExt, sizeOverride, lockPrefix, act, exp);
    end
  endtask

  task automatic runCase(int op, int mr, int f);
    int lm, rp, rw, rb, osz, lk, regF, md, rm, rexEff;
    int eByte, eWide, eShort, eValid, eMem, eWidth, eReg, eHigh, eFault;
    string tag, wtag;
    lm = f & 1; rp = (f >> 1) & 1; rw = (f >> 2) & 1;
    rb = (f >> 3) & 1; osz = (f >> 4) & 1; lk = (f >> 5) & 1;
    longMode = lm[0]; rexPresent = rp[0]; rexWide = rw[0]; rexRmExt = rb[0];
    sizeOverride = osz[0]; lockPrefix = lk[0];
    opcodeByte = op[7:0]; modrmByte = mr[7:0];
    #1;
    regF = (mr / 8) % 8; md = mr / 64; rm = mr % 8;
    rexEff = lm * rp;
    eByte  = (op == 254 && regF == 1) ? 1 : 0;
    eWide  = (op == 255 && regF == 1) ? 1 : 0;
    eShort = (lm == 0 && op >= 72 && op <= 79) ? 1 : 0;
    eValid = eByte + eWide + eShort;
    eMem   = ((eByte + eWide) == 1 && md != 3) ? 1 : 0;
    if (eValid == 0 || eByte == 1) eWidth = 0;
    else if (eWide == 1 && rexEff * rw == 1) eWidth = 3;
    else eWidth = (osz == 1) ? 1 : 2;
    if (eValid == 0 || eMem == 1) eReg = 0;
    else if (eShort == 1) eReg = op % 8;
    else eReg = 8 * rexEff * rb + rm;
    eHigh  = (eByte == 1 && eMem == 0 && rexEff == 0 && rm >= 4) ? 1 : 0;
    eFault = (eValid == 1 && lk == 1 && eMem == 0) ? 1 : 0;
    if (eByte == 1) tag = "R1";
    else if (eWide == 1) tag = "R2";
    else if (eShort == 1) tag = "R3";
    else if (lm == 1 && op >= 72 && op <= 79) tag = "R4";
    else tag = "R5";
    wtag = (lm == 0 && (rp + rw + rb) > 0) ? "R10" : tag;
    check(tag, "decValid", int'(decValid), eValid);
    check(wtag, "opWidth", int'(opWidth), eWidth);
    check("R6", "memOperand", int'(memOperand), eMem);
    check((wtag == "R10") ? "R10" : "R7", "regNum", int'(regNum), eReg);
    check("R8", "highByteReg", int'(highByteReg), eHigh);
    check("R9", "udFault", int'(udFault), eFault);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    runCase(0, 0, 0);  // R5 idle state after start
    for (int op = 254; op < 256; op++)
      for (int mr = 0; mr < 256; mr++)
        for (int f = 0; f < 64; f++)
          runCase(op, mr, f);
    for (int op = 0; op < 254; op++)
      for (int f = 0; f < 64; f++) begin
        runCase(op, 8'h0B, f);
        runCase(op, 8'hCF, f);
      end
    // named corner cases
    runCase(8'h4A, 8'hC0, 0);        // R3 legacy short form, reg 2, 32-bit
    runCase(8'h4A, 8'hC0, 1);        // R4 same byte in 64-bit mode
    runCase(8'hFE, 8'hCC, 0);        // R8 high byte, no REX
    runCase(8'hFE, 8'hCC, 3);        // R8 REX present selects low byte
    runCase(8'hFF, 8'hC9, 15);       // R2 REX.W width 64, R7 reg 9
    runCase(8'hFF, 8'h08, 32);       // R9 LOCK with memory, no fault
    runCase(8'hFF, 8'hC8, 32);       // R9 LOCK with register, fault
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule